// File: doc/BRIEF.md
# I2C Multi-Master Node with Arbitration

This block is one node on a shared two-wire open-drain bus. The node can work as a bus master and as an address-only slave. Given a command (7-bit target, read/write flag, one data byte), it issues a START, sends the address byte and, if the address is acknowledged, transfers one data byte: it sends the byte on a write and receives one on a read. It then issues a STOP. While it drives each bit, it reads the bus back in the middle of the clock-high phase. If it released the line for a 1 but sees a 0, another master has won. The node then lets go of both lines at once and pulses `arb_lost`.

A bus monitor runs all the time beside the master. It tracks START and STOP, shifts in every address byte, and compares the upper seven bits with the node's own address. A node that has just lost arbitration in the middle of an address is therefore already a slave receiver. It needs no hand-over. If the winning master is addressing this node, the node acknowledges in the ninth clock and pulses `addressed`. A node never acknowledges its own address while its own master is still running. No new START is issued while the bus is busy.

Both lines are modelled as wired-AND. The `*_oe` outputs pull a line low when high, and the `*_in` inputs return the resolved level. Master bits are timed in four quarters of `DIV` clock cycles each: SCL low, SDA change, SCL high, sample. There is no SCL synchronisation between masters, so competing masters stay aligned only when they start in the same cycle.

Top module: `i2c_mm_node`

## Requirements
- R1: During and right after reset, `scl_oe`, `sda_oe`, `busy`, `arb_lost`, `addressed`, `done` and `ack_ok` are all 0.
- R2: `busy` goes to 1 after a START on the bus (SDA falling while SCL is high) and returns to 0 after a STOP (SDA rising while SCL is high). Only the master FSM ever drives SCL.
- R3: A `cmd_start` given while `busy` is 1 and the node's master is idle is ignored. The node does not drive the bus and produces no `done` and no `arb_lost`.
- R4: The address byte is `{target[6:0], rw}` (rw=1 means read) and goes out MSB first. When two masters start together, the first differing bit decides: the master sending 0 wins and the other gets exactly one single-cycle `arb_lost` pulse.
- R5: In the cycle that `arb_lost` is 1, the node already releases both SCL and its master drive of SDA, and its transfer ends with no `done`.
- R6: Two masters sending identical bits for the whole transfer both complete, and each gives exactly one `done` and no `arb_lost`.
- R7: Arbitration is checked only on address bits and write-data bits the node drives. A 0 seen in an acknowledge slot or a read-data bit never counts as a loss.
- R8: After a loss in the address byte, the node keeps decoding that address. If the address equals `own_addr`, it pulls SDA low for the ninth clock and pulses `addressed` once.
- R9: A node whose master is active never acknowledges an address, including its own.
- R10: `done` is a one-cycle pulse after the STOP of a completed transfer. `ack_ok` then shows whether the address byte was acknowledged. A data byte follows only if it was.
- R11: On a read, the master releases SDA for all eight data bits and for the acknowledge bit (giving a not-acknowledge), and it shifts the bits into `rx_byte` MSB first. With no slave driving, `rx_byte` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | AW | This node's 7-bit slave address |
| cmd_start | input | 1 | Request one transfer (accepted when idle and bus free) |
| cmd_addr | input | AW | Target address |
| cmd_rw | input | 1 | 1 = read, 0 = write |
| cmd_data | input | AW+1 | Byte to write |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| busy | output | 1 | Bus is between START and STOP |
| arb_lost | output | 1 | One-cycle pulse on lost arbitration |
| addressed | output | 1 | One-cycle pulse when acknowledging own address |
| done | output | 1 | One-cycle pulse at end of a completed transfer |
| ack_ok | output | 1 | Address byte of the last own transfer was acknowledged |
| rx_byte | output | AW+1 | Byte received in the last read |

## Verification
The bench runs two nodes and an address-only third node together. It sweeps pairs of targets and both read/write flags, with data bytes that are either equal or differ in one bit. This covers losses at different address bits, losses in the data byte behind an identical address, and fully identical transfers. The hardest case is the loser being the winner's target: a design that switches role late or resets its address decode on a loss leaves the winner without an acknowledge. An acknowledge slot pulled low must not count as a loss, or a correct winner would drop out after the ninth clock. A START request while the bus is busy must not disturb the transfer already running on the bus.

// File: rtl/i2c_mm_pkg.sv
package i2c_mm_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_START = 2'd1,
    M_BIT   = 2'd2,
    M_STOP  = 2'd3
  } mst_state_e;
endpackage

// File: rtl/i2c_qtick.sv
// Quarter-bit tick: one pulse every DIV cycles while run is high.
module i2c_qtick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2c_mst_fsm.sv
// Master sequencer: START, address byte, optional data byte, STOP.
// Reads SDA back in the SCL-high quarter and drops out on a mismatch.
module i2c_mst_fsm
  import i2c_mm_pkg::*;
#(
  parameter int AW = 7,
  localparam int BW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_rw,
  input  logic [BW-1:0] cmd_data,
  input  logic          bus_busy,
  input  logic          sda_s,
  output logic          active,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          arb_lost,
  output logic          done,
  output logic          ack_ok,
  output logic [BW-1:0] rx_byte
);
  localparam int BCW = $clog2(BW + 1);
  localparam logic [BCW-1:0] ACK_IDX = BCW'(BW);

  mst_state_e     st;
  logic [1:0]     q;
  logic [BCW-1:0] bitn;
  logic           byte_n;
  logic           rw_q;
  logic [BW-1:0]  tx;
  logic [BW-1:0]  data_q;

  logic data_slot, drv, checked, reading;

  always_comb begin
    data_slot = (bitn != ACK_IDX);
    drv       = data_slot ? tx[BW-1] : 1'b1;
    checked   = data_slot && (!byte_n || !rw_q);
    reading   = data_slot && byte_n && rw_q;
  end

  assign active = (st != M_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= M_IDLE;
      q        <= 2'd0;
      bitn     <= '0;
      byte_n   <= 1'b0;
      rw_q     <= 1'b0;
      tx       <= '1;
      data_q   <= '0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      arb_lost <= 1'b0;
      done     <= 1'b0;
      ack_ok   <= 1'b0;
      rx_byte  <= '0;
    end else begin
      arb_lost <= 1'b0;
      done     <= 1'b0;
      unique case (st)
        M_IDLE: begin
          if (cmd_start && !bus_busy) begin
            st     <= M_START;
            q      <= 2'd0;
            sda_oe <= 1'b1;              // SDA falls while SCL high
            scl_oe <= 1'b0;
            tx     <= {cmd_addr, cmd_rw};
            data_q <= cmd_data;
            rw_q   <= cmd_rw;
            byte_n <= 1'b0;
            bitn   <= '0;
            ack_ok <= 1'b0;
          end
        end
        M_START: begin
          if (tick) begin
            if (q == 2'd1) begin
              st     <= M_BIT;
              q      <= 2'd0;
              scl_oe <= 1'b1;
            end else begin
              q <= q + 2'd1;
            end
          end
        end
        M_BIT: begin
          if (tick) begin
            unique case (q)
              2'd0: begin
                q      <= 2'd1;
                sda_oe <= !drv;
              end
              2'd1: begin
                q      <= 2'd2;
                scl_oe <= 1'b0;
              end
              2'd2: begin
                q <= 2'd3;
                if (reading) rx_byte <= {rx_byte[BW-2:0], sda_s};
                if (!data_slot && !byte_n) ack_ok <= !sda_s;
                if (checked && drv && !sda_s) begin
                  st       <= M_IDLE;
                  q        <= 2'd0;
                  scl_oe   <= 1'b0;
                  sda_oe   <= 1'b0;
                  arb_lost <= 1'b1;
                end
              end
              default: begin
                q      <= 2'd0;
                scl_oe <= 1'b1;
                if (!data_slot) begin
                  bitn <= '0;
                  if (!byte_n && ack_ok) begin
                    byte_n <= 1'b1;
                    tx     <= rw_q ? '1 : data_q;
                  end else begin
                    st <= M_STOP;
                  end
                end else begin
                  bitn <= bitn + 1'b1;
                  tx   <= {tx[BW-2:0], 1'b1};
                end
              end
            endcase
          end
        end
        default: begin // M_STOP
          if (tick) begin
            unique case (q)
              2'd0: begin q <= 2'd1; sda_oe <= 1'b1; end
              2'd1: begin q <= 2'd2; scl_oe <= 1'b0; end
              2'd2: begin q <= 2'd3; sda_oe <= 1'b0; end
              default: begin
                q    <= 2'd0;
                st   <= M_IDLE;
                done <= 1'b1;
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
// Always-on bus watcher: START/STOP tracking and address-only slave.
module i2c_bus_monitor #(
  parameter int AW = 7,
  localparam int BW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic [AW-1:0] own_addr,
  input  logic          mst_active,
  output logic          bus_busy,
  output logic          ack_oe,
  output logic          addressed
);
  localparam int CNTW = $clog2(BW + 2);
  localparam logic [CNTW-1:0] ACK_CNT = CNTW'(BW);
  localparam logic [CNTW-1:0] END_CNT = CNTW'(BW + 1);

  logic            scl_p, sda_p;
  logic [CNTW-1:0] cnt;
  logic [BW-1:0]   sh;
  logic            start_c, stop_c, rise, fall;

  always_comb begin
    start_c = scl_s && scl_p && sda_p && !sda_s;
    stop_c  = scl_s && scl_p && !sda_p && sda_s;
    rise    = scl_s && !scl_p;
    fall    = !scl_s && scl_p;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p     <= 1'b1;
      sda_p     <= 1'b1;
      cnt       <= END_CNT;
      sh        <= '0;
      bus_busy  <= 1'b0;
      ack_oe    <= 1'b0;
      addressed <= 1'b0;
    end else begin
      scl_p     <= scl_s;
      sda_p     <= sda_s;
      addressed <= 1'b0;
      if (start_c) begin
        bus_busy <= 1'b1;
        cnt      <= '0;
        ack_oe   <= 1'b0;
      end else if (stop_c) begin
        bus_busy <= 1'b0;
        cnt      <= END_CNT;
        ack_oe   <= 1'b0;
      end else begin
        if (rise && cnt < ACK_CNT) sh <= {sh[BW-2:0], sda_s};
        if (rise && cnt <= ACK_CNT) cnt <= cnt + 1'b1;
        if (fall && cnt == ACK_CNT && sh[BW-1:1] == own_addr && !mst_active) begin
          ack_oe    <= 1'b1;
          addressed <= 1'b1;
        end
        if (fall && cnt == END_CNT) ack_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_mm_node.sv
module i2c_mm_node #(
  parameter int AW = 7,
  parameter int DIV = 4,
  localparam int BW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] own_addr,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_rw,
  input  logic [BW-1:0] cmd_data,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          arb_lost,
  output logic          addressed,
  output logic          done,
  output logic          ack_ok,
  output logic [BW-1:0] rx_byte
);
  logic scl_s, sda_s;
  logic tick, mst_active, mst_sda_oe, slv_ack_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_s <= 1'b1;
      sda_s <= 1'b1;
    end else begin
      scl_s <= scl_in;
      sda_s <= sda_in;
    end
  end

  i2c_qtick #(.DIV(DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (mst_active),
    .tick(tick)
  );

  i2c_mst_fsm #(.AW(AW)) u_mst (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cmd_start(cmd_start),
    .cmd_addr (cmd_addr),
    .cmd_rw   (cmd_rw),
    .cmd_data (cmd_data),
    .bus_busy (busy),
    .sda_s    (sda_s),
    .active   (mst_active),
    .scl_oe   (scl_oe),
    .sda_oe   (mst_sda_oe),
    .arb_lost (arb_lost),
    .done     (done),
    .ack_ok   (ack_ok),
    .rx_byte  (rx_byte)
  );

  i2c_bus_monitor #(.AW(AW)) u_mon (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .own_addr  (own_addr),
    .mst_active(mst_active),
    .bus_busy  (busy),
    .ack_oe    (slv_ack_oe),
    .addressed (addressed)
  );

  assign sda_oe = mst_sda_oe | slv_ack_oe;
endmodule

// File: rtl/i2c_mm_node_chk.sv
module i2c_mm_node_chk (
  input logic clk,
  input logic rst,
  input logic arb_lost,
  input logic done,
  input logic addressed,
  input logic busy,
  input logic scl_oe,
  input logic mst_sda_oe,
  input logic slv_ack_oe,
  input logic mst_active
);
  assert_lost_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    arb_lost |=> !arb_lost);

  assert_release_on_loss_R5: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> (!scl_oe && !mst_sda_oe && !mst_active));

  assert_busy_blocks_start_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !mst_active) |=> !mst_active);

  assert_scl_master_only_R2: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> mst_active);

  assert_no_self_ack_R9: assert property (@(posedge clk) disable iff (rst)
    slv_ack_oe |-> !mst_active);

  assert_addressed_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    addressed |=> !addressed);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mst_active && !done_past_guard(done)));

  function automatic logic done_past_guard(input logic d);
    return 1'b0 & d;
  endfunction
endmodule

bind i2c_mm_node i2c_mm_node_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .arb_lost  (arb_lost),
  .done      (done),
  .addressed (addressed),
  .busy      (busy),
  .scl_oe    (scl_oe),
  .mst_sda_oe(mst_sda_oe),
  .slv_ack_oe(slv_ack_oe),
  .mst_active(mst_active)
);

// File: tb/sim_i2c_mm_node.sv
module sim_i2c_mm_node;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 7;
  localparam int BW  = AW + 1;
  localparam int DIV = 4;
  localparam logic [AW-1:0] A_ID = 7'h01;
  localparam logic [AW-1:0] B_ID = 7'h03;
  localparam logic [AW-1:0] C_ID = 7'h02;
  localparam int SETTLE = 420;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          a_go = 0, b_go = 0;
  logic [AW-1:0] a_t = '0, b_t = '0;
  logic          a_rw = 0, b_rw = 0;
  logic [BW-1:0] a_d = '0, b_d = '0;

  logic a_scl, a_sda, a_busy, a_lost, a_adr, a_done, a_ack;
  logic b_scl, b_sda, b_busy, b_lost, b_adr, b_done, b_ack;
  logic c_scl, c_sda, c_busy, c_lost, c_adr, c_done, c_ack;
  logic [BW-1:0] a_rx, b_rx, c_rx;
  logic scl_bus, sda_bus;

  assign scl_bus = !(a_scl | b_scl | c_scl);
  assign sda_bus = !(a_sda | b_sda | c_sda);

  i2c_mm_node #(.AW(AW), .DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .own_addr(A_ID), .cmd_start(a_go), .cmd_addr(a_t),
    .cmd_rw(a_rw), .cmd_data(a_d), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_oe(a_scl), .sda_oe(a_sda), .busy(a_busy), .arb_lost(a_lost),
    .addressed(a_adr), .done(a_done), .ack_ok(a_ack), .rx_byte(a_rx));

  i2c_mm_node #(.AW(AW), .DIV(DIV)) u1 (
    .clk(clk), .rst(rst), .own_addr(B_ID), .cmd_start(b_go), .cmd_addr(b_t),
    .cmd_rw(b_rw), .cmd_data(b_d), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_oe(b_scl), .sda_oe(b_sda), .busy(b_busy), .arb_lost(b_lost),
    .addressed(b_adr), .done(b_done), .ack_ok(b_ack), .rx_byte(b_rx));

  i2c_mm_node #(.AW(AW), .DIV(DIV)) u2 (
    .clk(clk), .rst(rst), .own_addr(C_ID), .cmd_start(1'b0), .cmd_addr('0),
    .cmd_rw(1'b0), .cmd_data('0), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_oe(c_scl), .sda_oe(c_sda), .busy(c_busy), .arb_lost(c_lost),
    .addressed(c_adr), .done(c_done), .ack_ok(c_ack), .rx_byte(c_rx));

  // pulse counters
  logic clr = 1'b0;
  int n_lost_a, n_lost_b, n_done_a, n_done_b, n_adr_a, n_adr_b, n_adr_c;
  always @(posedge clk) begin
    if (clr) begin
      n_lost_a <= 0; n_lost_b <= 0; n_done_a <= 0; n_done_b <= 0;
      n_adr_a <= 0; n_adr_b <= 0; n_adr_c <= 0;
    end else begin
      n_lost_a <= n_lost_a + int'(a_lost);
      n_lost_b <= n_lost_b + int'(b_lost);
      n_done_a <= n_done_a + int'(a_done);
      n_done_b <= n_done_b + int'(b_done);
      n_adr_a  <= n_adr_a + int'(a_adr);
      n_adr_b  <= n_adr_b + int'(b_adr);
      n_adr_c  <= n_adr_c + int'(c_adr);
    end
  end

  int n_vec = 0;
  int n_err = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  function automatic logic [AW-1:0] tgt(input int i);
    case (i)
      0: return A_ID;
      1: return C_ID;
      2: return B_ID;
      default: return 7'h42;
    endcase
  endfunction

  task automatic clear_counts();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // One transfer from A and/or B, started in the same cycle.
  task automatic run_pair(input logic [AW-1:0] ta, input logic ra, input logic [BW-1:0] da,
                          input logic [AW-1:0] tb, input logic rb, input logic [BW-1:0] db,
                          input bit goa, input bit gob);
    logic [BW-1:0] ba, bb;
    bit a_lose, b_lose, lost_addr, found, a_free, b_free, ack, rw_w;
    logic [AW-1:0] tw;
    a_lose = 0; b_lose = 0; lost_addr = 0; found = 0;
    ba = {ta, ra};
    bb = {tb, rb};
    tw = goa ? ta : tb;
    rw_w = goa ? ra : rb;
    if (goa && gob && ba != bb) begin
      lost_addr = 1;
      for (int i = BW - 1; i >= 0; i--) begin
        if (!found && ba[i] != bb[i]) begin
          found = 1;
          a_lose = ba[i];
          b_lose = bb[i];
        end
      end
      tw   = a_lose ? tb : ta;
      rw_w = a_lose ? rb : ra;
    end
    a_free = !goa || (a_lose && lost_addr);
    b_free = !gob || (b_lose && lost_addr);
    ack = (tw == C_ID) || (tw == A_ID && a_free) || (tw == B_ID && b_free);
    if (goa && gob && !lost_addr && ack && !ra && da != db) begin
      for (int i = BW - 1; i >= 0; i--) begin
        if (!found && da[i] != db[i]) begin
          found = 1;
          a_lose = da[i];
          b_lose = db[i];
        end
      end
    end

    clear_counts();
    @(negedge clk);
    a_t = ta; a_rw = ra; a_d = da; a_go = goa;
    b_t = tb; b_rw = rb; b_d = db; b_go = gob;
    @(negedge clk);
    a_go = 0; b_go = 0;
    repeat (SETTLE) @(negedge clk);

    chk("R4 lost pulses A", n_lost_a, int'(goa && a_lose));
    chk("R4 lost pulses B", n_lost_b, int'(gob && b_lose));
    chk("R5/R6/R10 done A", n_done_a, int'(goa && !a_lose));
    chk("R5/R6/R10 done B", n_done_b, int'(gob && !b_lose));
    chk("R8/R9 addressed A", n_adr_a, int'(tw == A_ID && a_free));
    chk("R8/R9 addressed B", n_adr_b, int'(tw == B_ID && b_free));
    chk("R7 addressed C", n_adr_c, int'(tw == C_ID));
    chk("R2 busy after STOP", int'(a_busy), 0);
    if (goa && !a_lose) begin
      chk("R10 ack_ok A", int'(a_ack), int'(ack));
      if (ack && rw_w) chk("R11 rx_byte A", int'(a_rx), 'hFF);
    end
    if (gob && !b_lose) begin
      chk("R10 ack_ok B", int'(b_ack), int'(ack));
      if (ack && rw_w) chk("R11 rx_byte B", int'(b_rx), 'hFF);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", int'(a_scl | b_scl | c_scl), 0);
    chk("R1 sda_oe", int'(a_sda | b_sda | c_sda), 0);
    chk("R1 status", int'({a_busy, a_lost, a_adr, a_done, a_ack}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", int'({a_scl, a_sda, a_busy, b_scl, b_sda, b_busy}), 0);

    // single masters
    run_pair(C_ID, 1'b0, 8'h96, '0, 1'b0, '0, 1, 0);
    run_pair(B_ID, 1'b1, 8'h00, '0, 1'b0, '0, 1, 0);
    run_pair('0, 1'b0, '0, A_ID, 1'b0, 8'h3C, 0, 1);
    run_pair(A_ID, 1'b0, 8'h11, '0, 1'b0, '0, 1, 0);   // R9 self address
    run_pair(7'h42, 1'b0, 8'h11, '0, 1'b0, '0, 1, 0);  // nobody answers

    // R3: start request while bus busy
    clear_counts();
    @(negedge clk);
    a_t = C_ID; a_rw = 0; a_d = 8'hC3; a_go = 1;
    @(negedge clk);
    a_go = 0;
    repeat (100) @(negedge clk);
    chk("R2 busy mid transfer", int'(b_busy), 1);
    b_t = A_ID; b_rw = 0; b_d = 8'h00; b_go = 1;
    @(negedge clk);
    b_go = 0;
    chk("R3 no drive from B", int'(b_scl | b_sda), 0);
    repeat (SETTLE) @(negedge clk);
    chk("R3 B done", n_done_b, 0);
    chk("R3 B lost", n_lost_b, 0);
    chk("R3 A done", n_done_a, 1);
    chk("R3 A ack_ok", int'(a_ack), 1);

    // two-master sweep: R4 R6 R7 R8
    for (int ia = 0; ia < 4; ia++)
      for (int ib = 0; ib < 4; ib++)
        for (int ra = 0; ra < 2; ra++)
          for (int rb = 0; rb < 2; rb++)
            for (int k = 0; k < 2; k++)
              run_pair(tgt(ia), ra[0], 8'h5A, tgt(ib), rb[0], (k == 0) ? 8'h5A : 8'h4A, 1, 1);

    report();
  end
endmodule